// File: doc/BRIEF.md
# Four-Channel DMA Controller Register Bank

This block is the processor-side register file of a four-channel legacy DMA controller. Software reaches it over a byte-wide I/O port bus. The bus has a 4-bit port number, separate read and write strobes, and 8-bit data in each direction. Each channel keeps 16-bit base and current copies of its address and its count. Each channel also has a mask bit and a 6-bit mode field. A single byte-pointer flip-flop is shared by all channels and splits every 16-bit register into a low-byte access followed by a high-byte access on the same port.

The transfer engine, which is outside this block, raises a one-cycle per-channel pulse for each unit it moves. On a pulse for an unmasked channel, the block steps the current address and decrements the current count. When the count wraps past zero, the block raises a terminal-count flag. The channel then either masks itself or, in auto-initialise mode, reloads its current registers from the base copies. A programmed count of N-1 moves N units.

Top module: `dmac_regbank`

## Requirements
- R1: After reset, all four masks are set, every mode field is zero, the status flags are clear, the byte pointer selects the low byte, and all address and count registers read as zero.
- R2: Port 2n is the address register and port 2n+1 is the count register of channel n, for n = 0 to 3. A 16-bit value is written as two byte writes to the same port, low byte first. A write updates the addressed byte of both the base and the current copy.
- R3: Every read or write of ports 0 to 7 flips the shared byte pointer. A write of any data to port 12 returns the pointer to the low byte.
- R4: A read of port 2n or 2n+1 returns the byte of the current address or current count that the pointer selects: low byte first, then high byte.
- R5: A write to port 10 sets or clears one mask bit. Data bits 1:0 select the channel; data bit 2 = 1 masks the channel and 0 unmasks it. Mask bit n appears on `chan_mask[n]`.
- R6: Any write to port 14 clears all four masks. A write to port 15 loads the masks from data bits 3:0, with bit n going to channel n.
- R7: A write to port 11 stores data bits 7:2 as the mode of the channel in data bits 1:0. Channel n's mode appears on `chan_mode[6n+5:6n]`.
- R8: A transfer pulse on an unmasked channel decrements the current count by one. It moves the current address by +1, or by -1 when mode-port data bit 5 was set. A pulse on a masked channel changes nothing.
- R9: A step from count 0 leaves count 0xFFFF and moves the address as usual. It sets that channel's terminal-count flag and, when mode-port data bit 4 is clear, sets the channel's mask.
- R10: When mode-port data bit 4 (auto-initialise) is set, a step from count 0 reloads the current address and count from the base copies. It sets the terminal-count flag and leaves the mask unchanged.
- R11: A read of port 8 returns the terminal-count flags in bits 3:0 (bit n = channel n), with bits 7:4 zero. The read clears the flags. A flag raised in the same cycle as the read survives it.
- R12: A write to port 13 sets all masks, returns the pointer to the low byte, and clears all modes and status flags. It leaves the address and count registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Port number |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle io_rd is high |
| xfer_pulse | input | 4 | One unit transferred, per channel |
| chan_mask | output | 4 | Mask state, bit n = channel n |
| chan_mode | output | 24 | Mode fields, 6 bits per channel |

## Verification
The bench probes the byte pointer across mixed reads and writes. A design that toggled only on writes, or that ignored the clear port, would assemble bytes in swapped order, and the 16-bit readbacks would come out scrambled. The zero-count wrap is run both with and without auto-initialise. A design that masked an auto-initialising channel, skipped the reload, or forgot to set the flag would show the wrong mask, wrong current registers or wrong status byte. The bench also checks that status reads are destructive, that pulses on masked channels are ignored, and that master reset keeps address contents while resetting the pointer.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int BYTE_W = 8;
   // Control port numbers; software depends on these values.
   typedef enum logic [3:0] {
      PORT_STATUS  = 4'd8,
      PORT_REQ     = 4'd9,
      PORT_MASK1   = 4'd10,
      PORT_MODE    = 4'd11,
      PORT_CLRPTR  = 4'd12,
      PORT_MRESET  = 4'd13,
      PORT_UNMASK  = 4'd14,
      PORT_MASKALL = 4'd15
   } ctl_port_e;
   // Bit positions inside the byte written to the mode port.
   localparam int MODE_AUTO_BIT = 4;
   localparam int MODE_DEC_BIT  = 5;
   localparam int MODE_LSB      = 2;
endpackage

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic flip,
   output logic hi
);
   always_ff @(posedge clk) begin
      if (!rst_n)     hi <= 1'b0;
      else if (clr)   hi <= 1'b0;
      else if (flip)  hi <= ~hi;
   end
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
   import dmac_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int MODE_W      = 6,
   parameter bit AUTOINIT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mreset,
   input  logic              wr_addr,
   input  logic              wr_cnt,
   input  logic              hi,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              step,
   output logic [CNT_W-1:0]  cur_addr,
   output logic [CNT_W-1:0]  cur_cnt,
   output logic [MODE_W-1:0] mode_q,
   output logic              tc_evt,
   output logic              tc_mask
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam int DEC_IDX  = MODE_DEC_BIT - MODE_LSB;
   localparam int AUTO_IDX = MODE_AUTO_BIT - MODE_LSB;

   logic [CNT_W-1:0] base_addr, base_cnt;
   logic             auto_on, step_eff, wrap;

   generate
      if (AUTOINIT_EN) begin : g_auto
         assign auto_on = mode_q[AUTO_IDX];
      end else begin : g_noauto
         assign auto_on = 1'b0;
      end
   endgenerate

   // A bus write to this channel's registers wins over a step.
   assign step_eff = step & ~wr_addr & ~wr_cnt;
   assign wrap     = step_eff && (cur_cnt == '0);
   assign tc_evt   = wrap;
   assign tc_mask  = wrap && !auto_on;

   function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] v,
                                                 input logic h,
                                                 input logic [BYTE_W-1:0] d);
      logic [CNT_W-1:0] r;
      r = v;
      if (h) r[2*BYTE_W-1:BYTE_W] = d;
      else   r[BYTE_W-1:0]        = d;
      return r;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_addr <= '0;
         base_cnt  <= '0;
         cur_addr  <= '0;
         cur_cnt   <= '0;
      end else begin
         if (wr_addr) begin
            base_addr <= put_byte(base_addr, hi, wdata);
            cur_addr  <= put_byte(cur_addr, hi, wdata);
         end
         if (wr_cnt) begin
            base_cnt <= put_byte(base_cnt, hi, wdata);
            cur_cnt  <= put_byte(cur_cnt, hi, wdata);
         end
         if (step_eff) begin
            if (wrap && auto_on) begin
               cur_addr <= base_addr;
               cur_cnt  <= base_cnt;
            end else begin
               cur_addr <= mode_q[DEC_IDX] ? cur_addr - ONE : cur_addr + ONE;
               cur_cnt  <= cur_cnt - ONE;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || mreset) mode_q <= '0;
      else if (mode_we)     mode_q <= mode_in;
   end
endmodule

// File: rtl/dmac_mask_status.sv
module dmac_mask_status
   import dmac_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mreset,
   input  logic              single_we,
   input  logic              clr_all,
   input  logic              load_all,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [NCH-1:0]    tc_set,
   input  logic [NCH-1:0]    tc_mask,
   input  logic              stat_rd,
   output logic [NCH-1:0]    mask,
   output logic [NCH-1:0]    status
);
   localparam int CH_BITS = $clog2(NCH);

   logic [NCH-1:0] mask_n, status_n;

   always_comb begin
      mask_n = mask | tc_mask;
      if (single_we) mask_n[wdata[CH_BITS-1:0]] = wdata[CH_BITS];
      if (clr_all)   mask_n = '0;
      if (load_all)  mask_n = wdata[NCH-1:0];
      if (mreset)    mask_n = '1;
   end

   always_comb begin
      status_n = (stat_rd ? '0 : status) | tc_set;
      if (mreset) status_n = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask   <= '1;
         status <= '0;
      end else begin
         mask   <= mask_n;
         status <= status_n;
      end
   end
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
   import dmac_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int CNT_W       = 16,
   parameter int MODE_W      = 6,
   parameter bit AUTOINIT_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [3:0]            io_addr,
   input  logic                  io_wr,
   input  logic                  io_rd,
   input  logic [7:0]            io_wdata,
   output logic [7:0]            io_rdata,
   input  logic [NCH-1:0]        xfer_pulse,
   output logic [NCH-1:0]        chan_mask,
   output logic [NCH*MODE_W-1:0] chan_mode
);
   localparam int CH_BITS    = $clog2(NCH);
   localparam int CHAN_PORTS = 2 * NCH;

   if (NCH != 4) begin : g_bad_nch
      $error("dmac_regbank: port map fixes NCH at 4");
   end
   if (CNT_W != 2 * BYTE_W) begin : g_bad_cnt
      $error("dmac_regbank: CNT_W must be two bytes");
   end
   if (MODE_W != BYTE_W - MODE_LSB) begin : g_bad_mode
      $error("dmac_regbank: MODE_W must match the mode byte field");
   end

   logic                is_chan, ptr_hi, mreset, stat_rd;
   logic [CH_BITS-1:0]  sel;
   logic [NCH-1:0]      stat_q, tc_set, tc_masked;
   logic [CNT_W-1:0]    ch_addr [NCH];
   logic [CNT_W-1:0]    ch_cnt  [NCH];

   assign is_chan = io_addr < 4'(CHAN_PORTS);
   assign sel     = io_addr[CH_BITS:1];
   assign mreset  = io_wr && (io_addr == PORT_MRESET);
   assign stat_rd = io_rd && (io_addr == PORT_STATUS);

   dmac_byte_ptr u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (mreset || (io_wr && io_addr == PORT_CLRPTR)),
      .flip ((io_wr || io_rd) && is_chan),
      .hi   (ptr_hi)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic              hit;
      logic [MODE_W-1:0] mode_i;
      assign hit = io_wr && is_chan && (sel == CH_BITS'(i));
      dmac_channel #(
         .CNT_W      (CNT_W),
         .MODE_W     (MODE_W),
         .AUTOINIT_EN(AUTOINIT_EN)
      ) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .mreset  (mreset),
         .wr_addr (hit && !io_addr[0]),
         .wr_cnt  (hit && io_addr[0]),
         .hi      (ptr_hi),
         .wdata   (io_wdata),
         .mode_we (io_wr && io_addr == PORT_MODE && io_wdata[CH_BITS-1:0] == CH_BITS'(i)),
         .mode_in (io_wdata[BYTE_W-1:MODE_LSB]),
         .step    (xfer_pulse[i] && !chan_mask[i]),
         .cur_addr(ch_addr[i]),
         .cur_cnt (ch_cnt[i]),
         .mode_q  (mode_i),
         .tc_evt  (tc_set[i]),
         .tc_mask (tc_masked[i])
      );
      assign chan_mode[i*MODE_W +: MODE_W] = mode_i;
   end

   dmac_mask_status #(.NCH(NCH)) u_ms (
      .clk      (clk),
      .rst_n    (rst_n),
      .mreset   (mreset),
      .single_we(io_wr && io_addr == PORT_MASK1),
      .clr_all  (io_wr && io_addr == PORT_UNMASK),
      .load_all (io_wr && io_addr == PORT_MASKALL),
      .wdata    (io_wdata),
      .tc_set   (tc_set),
      .tc_mask  (tc_masked),
      .stat_rd  (stat_rd),
      .mask     (chan_mask),
      .status   (stat_q)
   );

   always_comb begin
      logic [CNT_W-1:0] word;
      word     = io_addr[0] ? ch_cnt[sel] : ch_addr[sel];
      io_rdata = '0;
      if (io_rd) begin
         if (is_chan)      io_rdata = ptr_hi ? word[CNT_W-1:BYTE_W] : word[BYTE_W-1:0];
         else if (stat_rd) io_rdata = {{(BYTE_W-NCH){1'b0}}, stat_q};
      end
   end
endmodule

// File: rtl/dmac_regbank_chk.sv
module dmac_regbank_chk
   import dmac_pkg::*;
#(
   parameter int NCH = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic [3:0]     io_addr,
   input logic           io_wr,
   input logic           io_rd,
   input logic [7:0]     io_wdata,
   input logic [NCH-1:0] chan_mask,
   input logic           ptr_hi,
   input logic [NCH-1:0] tc_stat,
   input logic [NCH-1:0] tc_set,
   input logic [NCH-1:0] tc_mask_req
);
   // R3
   ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_CLRPTR) |=> !ptr_hi);

   // R3
   ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((io_wr || io_rd) && !io_addr[3]) |=> (ptr_hi != $past(ptr_hi)));

   // R12
   master_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_MRESET) |=> (chan_mask == '1 && tc_stat == '0 && !ptr_hi));

   // R5
   single_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_MASK1) |=> (chan_mask[$past(io_wdata[1:0])] == $past(io_wdata[2])));

   // R11
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == PORT_STATUS && tc_set == '0) |=> (tc_stat == '0));

   // R11
   status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_set != '0 && !(io_wr && io_addr == PORT_MRESET)) |=> ((tc_stat & $past(tc_set)) == $past(tc_set)));

   // R9
   self_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_mask_req != '0 && !(io_wr && (io_addr == PORT_MASK1 || io_addr == PORT_UNMASK || io_addr == PORT_MASKALL)))
      |=> ((chan_mask & $past(tc_mask_req)) == $past(tc_mask_req)));
endmodule

bind dmac_regbank dmac_regbank_chk #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .io_addr    (io_addr),
   .io_wr      (io_wr),
   .io_rd      (io_rd),
   .io_wdata   (io_wdata),
   .chan_mask  (chan_mask),
   .ptr_hi     (ptr_hi),
   .tc_stat    (stat_q),
   .tc_set     (tc_set),
   .tc_mask_req(tc_masked)
);

// File: tb/dmac_regbank_tb.sv
`timescale 1ns/1ps
module dmac_regbank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [3:0]  xfer_pulse = '0;
   logic [3:0]  chan_mask;
   logic [23:0] chan_mode;
   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   dmac_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .xfer_pulse(xfer_pulse),
      .chan_mask(chan_mask), .chan_mode(chan_mode)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] p, input logic [7:0] d);
      @(negedge clk);
      io_addr = p; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] p, output logic [7:0] d);
      @(negedge clk);
      io_addr = p; io_rd = 1'b1;
      #1 d = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic wr16(input logic [3:0] p, input logic [15:0] v);
      wr(4'd12, 8'h00);
      wr(p, v[7:0]);
      wr(p, v[15:8]);
   endtask

   task automatic rd16(input logic [3:0] p, output logic [15:0] v);
      logic [7:0] lo, hi;
      wr(4'd12, 8'h3C);
      rd(p, lo);
      rd(p, hi);
      v = {hi, lo};
   endtask

   task automatic pulse(input logic [3:0] m);
      @(negedge clk);
      xfer_pulse = m;
      @(negedge clk);
      xfer_pulse = '0;
   endtask

   task automatic t_reset();
      logic [7:0] b; logic [15:0] w;
      chk("R1 mask", chan_mask, 4'hF);
      chk("R1 mode", chan_mode, 24'h0);
      rd(4'd8, b);    chk("R1 status", b, 8'h00);
      rd16(4'd5, w);  chk("R1 count ch2", w, 16'h0);
   endtask

   task automatic t_regs();
      logic [15:0] w;
      wr16(4'd4, 16'h1234);
      wr16(4'd5, 16'h0005);
      rd16(4'd4, w); chk("R2 R4 addr ch2", w, 16'h1234);
      rd16(4'd5, w); chk("R2 R4 count ch2", w, 16'h0005);
   endtask

   task automatic t_ptr();
      logic [7:0] b; logic [15:0] w;
      wr(4'd12, 8'h00);
      wr(4'd0, 8'hAA);      // pointer now high
      wr(4'd12, 8'h5A);     // R3 clear regardless of data
      wr(4'd0, 8'h11);
      wr(4'd0, 8'h22);
      rd16(4'd0, w); chk("R3 clear then pair", w, 16'h2211);
      wr(4'd12, 8'h00);
      rd(4'd0, b);          // read flips the pointer to high
      wr(4'd0, 8'h77);      // lands in the high byte
      rd16(4'd0, w); chk("R3 read flips pointer", w, 16'h7711);
   endtask

   task automatic t_mask();
      wr(4'd10, 8'h02); chk("R5 unmask ch2", chan_mask, 4'hB);
      wr(4'd10, 8'h06); chk("R5 mask ch2", chan_mask, 4'hF);
      wr(4'd14, 8'hFF); chk("R6 clear all", chan_mask, 4'h0);
      wr(4'd15, 8'hA5); chk("R6 load all", chan_mask, 4'h5);
   endtask

   task automatic t_mode();
      wr(4'd11, 8'h45);
      wr(4'd11, 8'h4B);
      wr(4'd11, 8'hC0);
      chk("R7 ch1", chan_mode[11:6], 6'h11);
      chk("R7 ch3", chan_mode[23:18], 6'h12);
      chk("R7 ch0", chan_mode[5:0], 6'h30);
   endtask

   task automatic t_step();
      logic [7:0] b; logic [15:0] w;
      wr16(4'd0, 16'h0500);
      wr16(4'd2, 16'h0100);
      wr16(4'd3, 16'h0002);
      wr(4'd11, 8'h49);
      wr(4'd15, 8'h0D);
      pulse(4'b0011);
      rd16(4'd2, w); chk("R8 addr inc", w, 16'h0101);
      rd16(4'd3, w); chk("R8 count dec", w, 16'h0001);
      rd16(4'd0, w); chk("R8 masked ch0 ignored", w, 16'h0500);
      wr(4'd11, 8'h69);
      pulse(4'b0010);
      rd16(4'd2, w); chk("R8 addr dec", w, 16'h0100);
      pulse(4'b0010);
      chk("R9 self mask", chan_mask, 4'hF);
      rd16(4'd3, w); chk("R9 count wraps", w, 16'hFFFF);
      rd16(4'd2, w); chk("R9 addr still steps", w, 16'h00FF);
      rd(4'd8, b); chk("R11 status tc1", b, 8'h02);
      rd(4'd8, b); chk("R11 status cleared", b, 8'h00);
      pulse(4'b0010);
      rd16(4'd3, w); chk("R8 masked pulse ignored", w, 16'hFFFF);
   endtask

   task automatic t_auto();
      logic [15:0] w;
      wr16(4'd6, 16'h2000);
      wr16(4'd7, 16'h0001);
      wr(4'd11, 8'h5B);
      wr(4'd10, 8'h03);
      chk("R5 unmask ch3", chan_mask, 4'h7);
      pulse(4'b1000);
      pulse(4'b1000);
      chk("R10 mask kept", chan_mask, 4'h7);
      rd16(4'd6, w); chk("R10 addr reload", w, 16'h2000);
      rd16(4'd7, w); chk("R10 count reload", w, 16'h0001);
   endtask

   task automatic t_mreset();
      logic [7:0] b, lo, hi;
      rd(4'd0, b);          // leave the pointer on the high byte
      wr(4'd13, 8'h00);
      chk("R12 masks set", chan_mask, 4'hF);
      chk("R12 modes clear", chan_mode, 24'h0);
      rd(4'd2, lo);
      rd(4'd2, hi);
      chk("R12 pointer low, addr kept", {hi, lo}, 16'h00FF);
      rd(4'd8, b); chk("R12 status clear", b, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_ptr();
      t_mask();
      t_mode();
      t_step();
      t_auto();
      t_mreset();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule